// File: doc/BRIEF.md
# Programmable Periodic/One-Shot Down Timer

This block is a single countdown timer driven by an external microsecond tick strobe. Software arms it by writing one packed trigger word that carries an enable flag, a periodic-reload flag and a 29-bit reload count. The count register is loaded with that value and steps down by one on each tick strobe. When a tick arrives while the count is already zero, the timer expires and raises a level-high interrupt. Programming a count of N-1 therefore yields an expiry on the N-th tick.

In periodic mode the count reloads on expiry and the timer keeps running. In one-shot mode the enable flag drops and the count rests at zero. Software acknowledges the interrupt by writing a one to the acknowledge bit of a separate control word. Reading the control word returns the live remaining count and the pending interrupt flag.

Register access uses a single-cycle write strobe and a one-bit word select. Read data is a combinational function of the selected word.

Top module: `dtmr_top`

## Requirements
- R1: After reset the interrupt is low, the timer is disabled, and both words read back as zero.
- R2: A trigger-word write (select 0) stores bit 31 as enable, bit 30 as periodic and bits 28:0 as the reload value, and loads the count with that value in the same cycle. Reading the trigger word returns those fields in the same positions, with bit 29 reading 0.
- R3: The count changes only on a tick strobe while enabled, and then drops by exactly one. Ticks while disabled and cycles with no tick leave it unchanged.
- R4: With a programmed value of N-1, the interrupt rises the cycle after the N-th enabled tick.
- R5: In periodic mode the count reloads to the reload value on expiry, and the timer keeps expiring every N ticks.
- R6: In one-shot mode expiry clears the enable bit and leaves the count at zero. Later ticks raise no further expiry.
- R7: Writing an all-zero trigger word disables the timer, so later ticks change nothing and raise no interrupt.
- R8: Reading the control word (select 1) returns the count in bits 28:0 and the interrupt flag in bit 30. All other bits read 0.
- R9: A control-word write with bit 30 set clears the interrupt. A control-word write with bit 30 clear has no effect on it.
- R10: If an expiry and an acknowledge write fall in the same cycle, the interrupt stays set.
- R11: A trigger-word write restarts the count from the new value at once, even while the timer runs. A write that coincides with a tick takes precedence over that tick.
- R12: The full 29-bit count 0x1FFFFFFF loads, reads back and decrements correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe |
| acc_we | input | 1 | Register write strobe |
| acc_sel | input | 1 | Word select: 0 trigger word, 1 control word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
The hardest case to reach is an expiry and an acknowledge write landing in the very same cycle. A close second is a trigger write coinciding with a tick. Both need the count to sit at zero, with the interrupt already pending, exactly when the write arrives. The stimulus reaches this with a one-tick periodic interval: it advances the count tick by tick, confirms zero through the control word, and then issues the acknowledge write and the tick together. A reference model tracks every cycle, and a long mixed phase adds random ticks and writes that create further collisions.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 29;
    localparam int EN_BIT   = 31;
    localparam int PER_BIT  = 30;
    localparam int ACK_BIT  = 30;
    localparam int STAT_BIT = 30;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic en;
        logic per;
        cnt_t reload;
    } cfg_t;

    typedef enum logic {
        SEL_TRIG = 1'b0,
        SEL_CTRL = 1'b1
    } sel_e;
endpackage

// File: rtl/dtmr_cfg.sv
module dtmr_cfg
    import dtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    input  logic wr_en,
    input  logic wr_per,
    input  cnt_t wr_cnt,
    input  logic stop_req,
    output cfg_t cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (trig_wr) begin
            cfg_d.en     = wr_en;
            cfg_d.per    = wr_per;
            cfg_d.reload = wr_cnt;
        end else if (stop_req) begin
            cfg_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !trig_wr |=> !cfg_q.en);
    a_r7_zero_disable: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr && !wr_en && !wr_per && wr_cnt == '0 |=> !cfg_q.en && cfg_q.reload == '0);
    a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> cfg_q.en == $past(wr_en) && cfg_q.per == $past(wr_per));
endmodule

// File: rtl/dtmr_count.sv
module dtmr_count
    import dtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cnt_t load_val,
    input  logic en,
    input  logic per,
    input  cnt_t reload,
    output cnt_t count,
    output logic expire,
    output logic stop_req
);
    typedef struct packed {
        cnt_t count;
    } st_t;

    st_t  st_d, st_q;
    logic zero, step;

    assign zero     = (st_q.count == '0);
    assign step     = tick && en && !load;
    assign expire   = step && zero;
    assign stop_req = expire && !per;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.count = load_val;
        end else if (step) begin
            if (!zero)    st_d.count = st_q.count - 1'b1;
            else if (per) st_d.count = reload;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        tick && en && !load && count != '0 |=> count == $past(count) - 1'b1);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load && (!tick || !en) |=> $stable(count));
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire && per |=> count == $past(reload));
    a_r6_rest_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> count == '0);
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    typedef struct packed {
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)      st_d.pend = 1'b1;
        else if (clr) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.pend;

    a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set |=> !irq);
    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !set |=> $stable(irq));
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              acc_we,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              irq
);
    sel_e sel;
    logic trig_wr, ack_wr;
    cfg_t cfg;
    cnt_t count;
    logic expire, stop_req;
    logic unused_wbits;

    assign sel          = sel_e'(acc_sel);
    assign trig_wr      = acc_we && (sel == SEL_TRIG);
    assign ack_wr       = acc_we && (sel == SEL_CTRL) && acc_wdata[ACK_BIT];
    assign unused_wbits = ^acc_wdata[PER_BIT-1:CNT_W];

    dtmr_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_wr  (trig_wr),
        .wr_en    (acc_wdata[EN_BIT]),
        .wr_per   (acc_wdata[PER_BIT]),
        .wr_cnt   (acc_wdata[CNT_W-1:0]),
        .stop_req (stop_req),
        .cfg      (cfg)
    );

    dtmr_count u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (trig_wr),
        .load_val (acc_wdata[CNT_W-1:0]),
        .en       (cfg.en),
        .per      (cfg.per),
        .reload   (cfg.reload),
        .count    (count),
        .expire   (expire),
        .stop_req (stop_req)
    );

    dtmr_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (ack_wr),
        .irq   (irq)
    );

    always_comb begin
        acc_rdata = '0;
        if (sel == SEL_TRIG) begin
            acc_rdata[EN_BIT]      = cfg.en;
            acc_rdata[PER_BIT]     = cfg.per;
            acc_rdata[CNT_W-1:0]   = cfg.reload;
        end else begin
            acc_rdata[STAT_BIT]    = irq;
            acc_rdata[CNT_W-1:0]   = count;
        end
    end

    a_r8_ctrl_layout: assert property (@(posedge clk) disable iff (!rst_n)
        sel == SEL_CTRL |-> acc_rdata[STAT_BIT] == irq && acc_rdata[DATA_W-1] == 1'b0
                            && acc_rdata[CNT_W-1:0] == count);
    a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ack_wr |=> irq);
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !expire);
endmodule

// File: tb/sim_dtmr_top.sv
`timescale 1ns/1ps
module sim_dtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_sel = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    bit          m_en, m_per, m_irq;
    logic [28:0] m_reload, m_cnt;

    always #2.5 clk = ~clk;

    dtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .acc_we(acc_we),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        bit wt, wc, exp_now;
        if (!rst_n) begin
            m_en = 0; m_per = 0; m_irq = 0; m_reload = '0; m_cnt = '0;
        end else begin
            wt = acc_we && !acc_sel;
            wc = acc_we && acc_sel && acc_wdata[30];
            exp_now = tick && m_en && m_cnt == 0 && !wt;
            if (wt) begin
                m_en = acc_wdata[31]; m_per = acc_wdata[30];
                m_reload = acc_wdata[28:0]; m_cnt = acc_wdata[28:0];
            end else if (tick && m_en) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else if (m_per) m_cnt = m_reload;
                else m_en = 0;
            end
            if (exp_now) m_irq = 1;
            else if (wc) m_irq = 0;
        end
    end

    function automatic logic [31:0] model_rd(input logic s);
        logic [31:0] v = '0;
        if (!s) begin v[31] = m_en; v[30] = m_per; v[28:0] = m_reload; end
        else    begin v[30] = m_irq; v[28:0] = m_cnt; end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic s, input logic [31:0] d, input logic t);
        @(negedge clk);
        if (rst_n) begin
            chk({cur_req, " model irq"}, {31'd0, irq}, {31'd0, m_irq});
            chk({cur_req, " model rdata"}, acc_rdata, model_rd(acc_sel));
        end
        acc_we = we; acc_sel = s; acc_wdata = d; tick = t;
    endtask

    task automatic peek(input logic s, input logic [31:0] exp, input string tag);
        drive(0, s, 0, 0);
        #1;
        chk(tag, acc_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 1, 0, 1);
            drive(0, 1, 0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        peek(0, 32'h0, "R1 trigger after reset");
        peek(1, 32'h0, "R1 control after reset");
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        cur_req = "R2";
        drive(1, 0, 32'hC000_0004, 0);
        peek(0, 32'hC000_0004, "R2 trigger readback");
        peek(1, 32'h0000_0004, "R2 count loaded");

        cur_req = "R3";
        drive(1, 0, 32'h0000_0005, 0);
        ticks(3);
        peek(1, 32'h0000_0005, "R3 disabled ticks ignored");
        drive(1, 0, 32'h8000_0009, 0);
        repeat (4) drive(0, 1, 0, 0);
        peek(1, 32'h0000_0009, "R3 no tick no change");
        ticks(2);
        peek(1, 32'h0000_0007, "R3 two ticks");

        cur_req = "R4";
        drive(1, 0, 32'h8000_0002, 0);
        drive(0, 1, 0, 1);
        drive(0, 1, 0, 1);
        peek(1, 32'h0000_0000, "R4 no irq before third tick");
        drive(0, 1, 0, 1);
        peek(1, 32'h4000_0000, "R4 irq after third tick");

        cur_req = "R6";
        peek(0, 32'h0000_0002, "R6 enable cleared");
        ticks(3);
        peek(1, 32'h4000_0000, "R6 count rests at zero");

        cur_req = "R9";
        drive(1, 1, 32'hBFFF_FFFF, 0);
        peek(1, 32'h4000_0000, "R9 write without ack bit");
        drive(1, 1, 32'h4000_0000, 0);
        peek(1, 32'h0000_0000, "R9 ack clears irq");

        cur_req = "R5";
        drive(1, 0, 32'hC000_0001, 0);
        ticks(2);
        peek(1, 32'h4000_0001, "R5 reload after expiry");
        drive(1, 1, 32'h4000_0000, 0);
        ticks(2);
        peek(1, 32'h4000_0001, "R5 second period");
        peek(0, 32'hC000_0001, "R5 still enabled");
        drive(1, 1, 32'h4000_0000, 0);

        cur_req = "R8";
        peek(1, 32'h0000_0001, "R8 control layout after ack");

        cur_req = "R10";
        ticks(2);
        drive(0, 1, 0, 1);
        peek(1, 32'h4000_0000, "R10 setup at zero with irq");
        drive(1, 1, 32'h4000_0000, 1);
        peek(1, 32'h4000_0001, "R10 irq kept on collision");

        cur_req = "R11";
        drive(1, 0, 32'hC000_0010, 1);
        peek(1, 32'h4000_0010, "R11 write beats tick");
        drive(0, 1, 0, 1);
        peek(1, 32'h4000_000F, "R11 running after restart");
        drive(1, 0, 32'hC000_0003, 0);
        peek(1, 32'h4000_0003, "R11 restart while running");
        drive(1, 1, 32'h4000_0000, 0);

        cur_req = "R7";
        drive(1, 0, 32'h0, 0);
        peek(0, 32'h0, "R7 zero write disables");
        ticks(3);
        peek(1, 32'h0, "R7 no count no irq");

        cur_req = "R12";
        drive(1, 0, 32'h9FFF_FFFF, 0);
        peek(0, 32'h9FFF_FFFF, "R12 max trigger");
        peek(1, 32'h1FFF_FFFF, "R12 max count");
        drive(0, 1, 0, 1);
        peek(1, 32'h1FFF_FFFE, "R12 max decrement");

        cur_req = "mix";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            logic s = $urandom_range(0, 1);
            logic t = ($urandom_range(0, 2) != 0);
            if (r < 4)
                drive(1, 0, {1'b1, 1'($urandom_range(0, 1)), 1'b0, 29'($urandom_range(0, 6))}, t);
            else if (r < 10)
                drive(1, 1, {1'b0, 1'($urandom_range(0, 1)), 30'd0}, t);
            else if (r < 11)
                drive(1, 0, 32'h0, t);
            else
                drive(0, s, 0, t);
        end
        drive(0, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule